// File: doc/BRIEF.md
# Banked Three-Port Data Store Arbiter

This block lets one set of single-ported storage banks serve two readers and one writer in the same clock cycle. The words are spread over eight banks, chosen by the address bits just above the byte-in-word offset, so neighbouring words land in different banks. Every request whose bank no other request wants is granted in the cycle it is presented. A write goes into its bank at the clock edge that ends its grant cycle. A granted read returns its word one cycle later, together with a one-cycle valid pulse.

When two or more requests want the same bank, one of them is granted and the others are stalled. The order is fixed: read port 0 first, then read port 1, then the write port. A stalled requester keeps its request and its inputs unchanged and tries again in the next cycle. A read and a write to the same bank are never granted together, so a read never sees a word that is being written. Tag lookup, way choice and miss handling are done elsewhere. Addresses here are plain word locations inside the banked store.

Top module: `bcaa_top`

## Requirements
- R1: While reset is asserted, both read-valid outputs are low, and asserting reset clears a pending read-valid at once.
- R2: With 32-bit words, address bits [1:0] are a byte offset that is ignored. Bits [4:2] pick the bank (0 to 7), and bits [8:5] pick the word inside the bank. Two addresses that differ only in bits [1:0] reach the same word.
- R3: A grant is only ever asserted for a port whose request is high. It is combinational and is high exactly in the cycle of the bank access.
- R4: Requests that target pairwise different banks are all granted in the same cycle.
- R5: When requests share a bank, exactly one is granted. Read port 0 beats read port 1, and read port 1 beats the write port.
- R6: A read and a write that target the same bank are never granted in the same cycle. The write is stalled.
- R7: One cycle after a read grant, the port's valid output is high for exactly one cycle, and its data output carries the word most recently written to that address. With no grant, the valid output is low.
- R8: A write changes the stored word only in a cycle where it is granted. A stalled write leaves the storage untouched.
- R9: A stalled request that is held unchanged is granted in a later cycle once its bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd0_req | input | 1 | Read port 0 request |
| rd0_addr | input | 16 | Read port 0 byte address |
| rd0_gnt | output | 1 | Read port 0 granted this cycle |
| rd0_rvalid | output | 1 | Read port 0 data valid (one cycle after grant) |
| rd0_rdata | output | 32 | Read port 0 data |
| rd1_req | input | 1 | Read port 1 request |
| rd1_addr | input | 16 | Read port 1 byte address |
| rd1_gnt | output | 1 | Read port 1 granted this cycle |
| rd1_rvalid | output | 1 | Read port 1 data valid (one cycle after grant) |
| rd1_rdata | output | 32 | Read port 1 data |
| wr_req | input | 1 | Write port request |
| wr_addr | input | 16 | Write port byte address |
| wr_wdata | input | 32 | Write data |
| wr_gnt | output | 1 | Write port granted this cycle |

## Verification
The arbiter is driven with several kinds of traffic:
- All three ports on pairwise different banks, which shows that the banks work in parallel.
- Both readers on one bank, which isolates the read-port priority.
- A reader and the writer on one bank, which shows that the write yields and that a stalled write leaves the stored word as it was.
- Two addresses in the same bank but on different rows, which shows that the bank bits alone decide a conflict.
- Byte offsets inside a word and the highest bank number, which confirm the address slicing.

Each stalled request is then presented again unchanged, which shows that it is granted once its bank is free.

// File: rtl/bcaa_pkg.sv
package bcaa_pkg;
  // Port slots in priority order: lower index wins a bank conflict.
  localparam int NUM_PORTS = 3;
  typedef enum logic [1:0] {
    SLOT_RD0 = 2'd0,
    SLOT_RD1 = 2'd1,
    SLOT_WR  = 2'd2
  } slot_e;
endpackage

// File: rtl/bcaa_arbiter.sv
module bcaa_arbiter
  import bcaa_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             req,
  input  logic [NUM_PORTS-1:0][BANK_W-1:0] bank,
  output logic [NUM_PORTS-1:0]             gnt
);
  logic hit_01, hit_02, hit_12;

  always_comb begin
    hit_01 = (bank[SLOT_RD0] == bank[SLOT_RD1]);
    hit_02 = (bank[SLOT_RD0] == bank[SLOT_WR]);
    hit_12 = (bank[SLOT_RD1] == bank[SLOT_WR]);
    gnt[SLOT_RD0] = req[SLOT_RD0];
    gnt[SLOT_RD1] = req[SLOT_RD1] && !(req[SLOT_RD0] && hit_01);
    gnt[SLOT_WR]  = req[SLOT_WR] && !(req[SLOT_RD0] && hit_02)
                                 && !(req[SLOT_RD1] && hit_12);
  end

  // R3: no grant without a request
  a_r3_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R4: lone reader on its bank always proceeds
  a_r4_rd1_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (req[SLOT_RD1] && (!req[SLOT_RD0] || bank[SLOT_RD0] != bank[SLOT_RD1]))
      |-> gnt[SLOT_RD1]);
  // R5: read port 0 is never stalled, and no bank gets two grants
  a_r5_rd0_top: assert property (@(posedge clk) disable iff (!rst_n)
    req[SLOT_RD0] |-> gnt[SLOT_RD0]);
  a_r5_single_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[SLOT_RD0] && gnt[SLOT_RD1]) |-> (bank[SLOT_RD0] != bank[SLOT_RD1]));
  // R6: read and write never share a bank in one cycle
  a_r6_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[SLOT_WR] |-> !(gnt[SLOT_RD0] && bank[SLOT_RD0] == bank[SLOT_WR])
                  && !(gnt[SLOT_RD1] && bank[SLOT_RD1] == bank[SLOT_WR]));
endmodule

// File: rtl/bcaa_bank.sv
module bcaa_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Single port: one read or one write per cycle, read data registered.
  always_ff @(posedge clk) begin
    if (en && we)  mem[row] <= wdata;
    if (en && !we) rdata    <= mem[row];
  end
endmodule

// File: rtl/bcaa_top.sv
module bcaa_top
  import bcaa_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd0_req,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic              rd0_gnt,
  output logic              rd0_rvalid,
  output logic [DATA_W-1:0] rd0_rdata,
  input  logic              rd1_req,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic              rd1_gnt,
  output logic              rd1_rvalid,
  output logic [DATA_W-1:0] rd1_rdata,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_wdata,
  output logic              wr_gnt
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = $clog2(BANK_DEPTH);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Address slicing per port.
  logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
  logic [NUM_PORTS-1:0][BANK_W-1:0] p_bank;
  logic [NUM_PORTS-1:0][ROW_W-1:0]  p_row;
  logic [NUM_PORTS-1:0]             p_req, p_gnt;

  assign p_addr = {wr_addr, rd1_addr, rd0_addr};
  assign p_req  = {wr_req, rd1_req, rd0_req};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slice
    assign p_bank[p] = p_addr[p][OFF_W +: BANK_W];
    assign p_row[p]  = p_addr[p][OFF_W + BANK_W +: ROW_W];
  end

  bcaa_arbiter #(.BANK_W(BANK_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (p_req),
    .bank  (p_bank),
    .gnt   (p_gnt)
  );

  assign rd0_gnt = p_gnt[SLOT_RD0];
  assign rd1_gnt = p_gnt[SLOT_RD1];
  assign wr_gnt  = p_gnt[SLOT_WR];

  // Bank steering: at most one granted port per bank, taken in priority order.
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             b_en, b_we;
    logic [ROW_W-1:0] b_row;

    always_comb begin
      b_en  = 1'b0;
      b_we  = 1'b0;
      b_row = '0;
      if (p_gnt[SLOT_RD0] && p_bank[SLOT_RD0] == BANK_W'(b)) begin
        b_en  = 1'b1;
        b_row = p_row[SLOT_RD0];
      end else if (p_gnt[SLOT_RD1] && p_bank[SLOT_RD1] == BANK_W'(b)) begin
        b_en  = 1'b1;
        b_row = p_row[SLOT_RD1];
      end else if (p_gnt[SLOT_WR] && p_bank[SLOT_WR] == BANK_W'(b)) begin
        b_en  = 1'b1;
        b_we  = 1'b1;
        b_row = p_row[SLOT_WR];
      end
    end

    bcaa_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk   (clk),
      .en    (b_en),
      .we    (b_we),
      .row   (b_row),
      .wdata (wr_wdata),
      .rdata (bank_rdata[b])
    );
  end

  // Read return: valid pulse and the bank to pick, one cycle after grant.
  logic [1:0]             rv_d, rv_q;
  logic [1:0][BANK_W-1:0] sel_d, sel_q;
  logic [1:0]             sel_en;

  always_comb begin
    rv_d   = {p_gnt[SLOT_RD1], p_gnt[SLOT_RD0]};
    sel_en = rv_d;
    sel_d  = {p_bank[SLOT_RD1], p_bank[SLOT_RD0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
    end else if (!rst_int_n) begin
      rv_q <= '0;
    end else begin
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      if (sel_en[0]) sel_q[0] <= sel_d[0];
      if (sel_en[1]) sel_q[1] <= sel_d[1];
    end
  end

  assign rd0_rvalid = rv_q[0];
  assign rd1_rvalid = rv_q[1];
  assign rd0_rdata  = bank_rdata[sel_q[0]];
  assign rd1_rdata  = bank_rdata[sel_q[1]];

  // R7: valid follows a grant by one cycle, and only a grant
  a_r7_rd0_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd0_gnt |=> rd0_rvalid);
  a_r7_rd1_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd1_gnt |=> !rd1_rvalid);
  // R9: stalled requests are held by the requester until granted
  a_r9_rd1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_req && !rd1_gnt) |=> (rd1_req && $stable(rd1_addr)));
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_wdata)));
  // R1: nothing valid while reset is low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(rd0_rvalid || rd1_rvalid));
endmodule

// File: tb/bcaa_top_tb.sv
`timescale 1ns/1ps
module bcaa_top_tb;
  localparam int  CLK_HALF = 10;   // 50 MHz
  localparam int  NV = 17;

  typedef struct packed {
    logic        r0v;
    logic [15:0] r0a;
    logic        r1v;
    logic [15:0] r1a;
    logic        wv;
    logic [15:0] wa;
    logic [31:0] wd;
    logic [2:0]  eg;   // expected {rd0_gnt, rd1_gnt, wr_gnt}
  } vec_t;

  // Bank = addr[4:2], row = addr[8:5].
  localparam vec_t VEC [NV] = '{
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0000, 32'h1111_0000, 3'b001}, // 0 fill b0r0
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0004, 32'h2222_0004, 3'b001}, // 1 fill b1r0
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0008, 32'h3333_0008, 3'b001}, // 2 fill b2r0
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0020, 32'h4444_0020, 3'b001}, // 3 fill b0r1
    '{1'b1,16'h0000, 1'b1,16'h0004, 1'b1,16'h000C, 32'h5555_000C, 3'b111}, // 4 R4 all distinct
    '{1'b1,16'h0000, 1'b1,16'h0020, 1'b0,16'h0000, 32'h0,         3'b100}, // 5 R5 same bank, other row
    '{1'b0,16'h0000, 1'b1,16'h0020, 1'b0,16'h0000, 32'h0,         3'b010}, // 6 R9 retry
    '{1'b1,16'h0004, 1'b1,16'h0008, 1'b1,16'h0024, 32'h6666_0024, 3'b110}, // 7 R6 write yields
    '{1'b1,16'h0003, 1'b1,16'h0009, 1'b1,16'h0024, 32'h6666_0024, 3'b111}, // 8 R2 offsets, R9
    '{1'b1,16'h0024, 1'b1,16'h0024, 1'b0,16'h0000, 32'h0,         3'b100}, // 9 R5 identical addr
    '{1'b0,16'h0000, 1'b1,16'h0024, 1'b0,16'h0000, 32'h0,         3'b010}, // 10 R9 retry
    '{1'b0,16'h0000, 1'b1,16'h0000, 1'b1,16'h0000, 32'h7777_0000, 3'b010}, // 11 R5 rd1 over wr
    '{1'b1,16'h0000, 1'b0,16'h0000, 1'b1,16'h0000, 32'h7777_0000, 3'b100}, // 12 R8 old data
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0000, 32'h7777_0000, 3'b001}, // 13 R9 write lands
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h001C, 32'h8888_001C, 3'b001}, // 14 top bank
    '{1'b1,16'h001C, 1'b1,16'h0000, 1'b1,16'h0008, 32'h9999_0008, 3'b111}, // 15 R7 new data
    '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 32'h0,         3'b000}  // 16 idle
  };

  logic        clk, rst_n;
  logic        rd0_req, rd1_req, wr_req;
  logic [15:0] rd0_addr, rd1_addr, wr_addr;
  logic [31:0] wr_wdata, rd0_rdata, rd1_rdata;
  logic        rd0_gnt, rd1_gnt, wr_gnt, rd0_rvalid, rd1_rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] mdl [128];
  logic        pend0, pend1;
  logic [31:0] pexp0, pexp1;

  bcaa_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_req(rd0_req), .rd0_addr(rd0_addr), .rd0_gnt(rd0_gnt),
    .rd0_rvalid(rd0_rvalid), .rd0_rdata(rd0_rdata),
    .rd1_req(rd1_req), .rd1_addr(rd1_addr), .rd1_gnt(rd1_gnt),
    .rd1_rvalid(rd1_rvalid), .rd1_rdata(rd1_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_wdata(wr_wdata), .wr_gnt(wr_gnt)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reads();
    chk(rd0_rvalid == pend0, "R7 rd0 valid", 32'(rd0_rvalid), 32'(pend0));
    if (pend0) chk(rd0_rdata == pexp0, "R7 R8 R2 rd0 data", rd0_rdata, pexp0);
    chk(rd1_rvalid == pend1, "R7 rd1 valid", 32'(rd1_rvalid), 32'(pend1));
    if (pend1) chk(rd1_rdata == pexp1, "R7 R8 R2 rd1 data", rd1_rdata, pexp1);
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    check_reads();
    rd0_req = v.r0v; rd0_addr = v.r0a;
    rd1_req = v.r1v; rd1_addr = v.r1a;
    wr_req  = v.wv;  wr_addr  = v.wa; wr_wdata = v.wd;
    #5;
    chk({rd0_gnt, rd1_gnt, wr_gnt} == v.eg, "R3 R4 R5 R6 R9 grants",
        32'({rd0_gnt, rd1_gnt, wr_gnt}), 32'(v.eg));
    pend0 = v.eg[2];
    pend1 = v.eg[1];
    pexp0 = mdl[v.r0a[8:2]];
    pexp1 = mdl[v.r1a[8:2]];
    if (v.eg[0]) mdl[v.wa[8:2]] = v.wd;
  endtask

  initial begin
    #(64'd200000 * 2 * CLK_HALF);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rd0_req = 0; rd1_req = 0; wr_req = 0;
    rd0_addr = '0; rd1_addr = '0; wr_addr = '0; wr_wdata = '0;
    pend0 = 0; pend1 = 0; pexp0 = '0; pexp1 = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(!rd0_rvalid && !rd1_rvalid, "R1 valid in reset",
        32'({rd0_rvalid, rd1_rvalid}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) apply(VEC[i]);
    @(negedge clk);
    check_reads();

    // R1: reset clears a pending valid without waiting for an edge
    rd0_req = 1'b1; rd0_addr = 16'h0004;
    @(negedge clk);
    rd0_req = 1'b0;
    chk(rd0_rvalid && rd0_rdata == 32'h2222_0004, "R7 rd0 before reset",
        rd0_rdata, 32'h2222_0004);
    rst_n = 1'b0;
    #1;
    chk(!rd0_rvalid, "R1 async clear", 32'(rd0_rvalid), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd0_rvalid && !rd1_rvalid, "R1 after release",
        32'({rd0_rvalid, rd1_rvalid}), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule